// File: doc/BRIEF.md
# Configurable Four-Input Logic Cell with Carry and Scan-Loaded Setup

This block is one logic cell of a programmable fabric tile. A 16-entry truth table selected by four data inputs gives any Boolean function of those inputs on the combinational output. Setting one setup bit turns the same 16 bits into a small 16x1 memory. The memory is written on the rising clock edge and read without a clock. A carry stage lets neighbouring cells form ripple adders. An output flip-flop has selectable data source, synchronous set and reset, and programmable polarity. It drives the registered output.

The whole setup is 31 bits held in one shift register. It is loaded serially, least significant bit first, through a scan input. The oldest bit leaves through a scan output, so cells can be daisy-chained and read back. While the chain is shifting, the user clock has no effect. The flip-flop holds its value and memory writes are blocked.

Top module: `lut_logic_block`

## Requirements
- R1: A low `rst_n` at a rising edge clears all 31 setup bits and `yq`. After reset the cell is in carry pass-through mode, so `cout` follows `cin`.
- R2: While `cfg_shift_en` is high, each rising edge moves `cfg_sin` into bit 30 and shifts the other bits down by one. `cfg_sout` always shows bit 0, so 31 shifts place the first bit sent at bit 0 and return the previous contents in order, LSB first.
- R3: Bits 15:0 form the table T. Outside carry-add mode, `y` equals T[{a[3],a[2],a[1],a[0]}].
- R4: When bit 16 (memory mode) is 1, `we` is high and no shift is in progress, a rising edge writes `wd` into T[a]. `y` shows the new bit at once, without waiting for a further clock, and the written bits come out through the scan chain.
- R5: When bit 16 is 0, `we` and `wd` leave T unchanged.
- R6: Bits 18:17 select the carry mode.
  - 00: `cout` = `cin`.
  - 01: `y` = a[0]^a[1]^`cin` and `cout` = majority(a[0], a[1], `cin`).
  - 10: `cout` = T[a].
  - 11: `cout` = 0.
- R7: Bits 22:21 select the flip-flop data.
  - 00: `y`.
  - 01: `d_in`.
  - 10: `cout`.
  - 11: hold the current value.
- R8: Bit 20 enables set/reset and bit 19 gives the active level (1 = active high). A `ff_rst` that is active at an edge clears `yq`, and takes priority over an active `ff_set`. An active `ff_set` alone sets `yq`. With bit 20 at 0, both inputs are ignored.
- R9: While `cfg_shift_en` is high, `yq` keeps its value whatever the data and set/reset inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the setup chain, the memory and the flip-flop |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_shift_en | input | 1 | Shift the setup chain and freeze user clocking |
| cfg_sin | input | 1 | Serial setup input |
| cfg_sout | output | 1 | Serial setup output (bit 0) |
| a | input | 4 | Table select, memory address, carry operands a[0], a[1] |
| cin | input | 1 | Carry from the previous cell |
| we | input | 1 | Memory write enable |
| wd | input | 1 | Memory write data |
| d_in | input | 1 | Direct flip-flop data |
| ff_set | input | 1 | Synchronous set request |
| ff_rst | input | 1 | Synchronous reset request |
| y | output | 1 | Combinational output |
| yq | output | 1 | Registered output |
| cout | output | 1 | Carry to the next cell |

## Verification
The bench builds the cell with its default four table inputs and eight spare setup bits. At that size every input pattern can be swept. Each of several truth tables is checked against all 16 select values. Every operand and carry-in combination is checked in each carry mode. All 16 memory addresses are written and then read back both on `y` and through the scan chain. Full 31-bit readback shows the LSB-first order and the reset contents. Short clocked sequences walk the flip-flop through each data source, both set/reset polarities, the reset-over-set priority and the freeze during shifting.

// File: rtl/lut_lb_pkg.sv
// Shared types for the logic cell: carry-mode and flip-flop-source encodings,
// and the number of mode bits that sit above the truth table.
package lut_lb_pkg;
    typedef enum logic [1:0] {
        CARRY_PASS = 2'b00,
        CARRY_ADD  = 2'b01,
        CARRY_GEN  = 2'b10,
        CARRY_ZERO = 2'b11
    } carry_mode_e;

    typedef enum logic [1:0] {
        SRC_COMB   = 2'b00,
        SRC_DIRECT = 2'b01,
        SRC_CARRY  = 2'b10,
        SRC_HOLD   = 2'b11
    } ff_src_e;

    // memory mode (1) + carry mode (2) + set/reset polarity and enable (2) + source (2)
    localparam int MODE_BITS = 7;
endpackage

// File: rtl/lb_cfg_chain.sv
// Setup storage: an N-bit shift register loaded LSB first, whose low 2**K bits
// can also be written one at a time as a small memory.
// Assumes the caller has already gated wr_en against shifting and mode.
module lb_cfg_chain #(
    parameter int N = 31,
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         sin,
    input  logic         wr_en,
    input  logic [K-1:0] wr_addr,
    input  logic         wr_data,
    output logic [N-1:0] cfg_q,
    output logic         sout
);
    // Reset, shift toward bit 0, or single-bit memory write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (shift_en) begin
            cfg_q <= {sin, cfg_q[N-1:1]};
        end else if (wr_en) begin
            cfg_q[wr_addr] <= wr_data;
        end
    end

    // Oldest bit leaves the chain.
    assign sout = cfg_q[0];
endmodule

// File: rtl/lb_lut.sv
// K-input look-up: selects one entry of a 2**K-bit table. Used both as the
// logic function and as the untimed read port of the memory mode.
module lb_lut #(
    parameter int K = 4,
    localparam int TBL = 1 << K
) (
    input  logic [TBL-1:0] table_bits,
    input  logic [K-1:0]   sel,
    output logic           out
);
    // Table entry picked by the select inputs.
    assign out = table_bits[sel];
endmodule

// File: rtl/lb_carry.sv
// Carry stage: a full-adder sum and carry from a[0], a[1] and cin, or a
// pass, generate-from-table or constant-zero carry, as chosen by mode.
module lb_carry
    import lut_lb_pkg::*;
(
    input  logic        op0,
    input  logic        op1,
    input  logic        cin,
    input  logic        lut_o,
    input  carry_mode_e mode,
    output logic        sum,
    output logic        cout
);
    // Sum is always the adder result; the top decides whether to use it.
    always_comb begin
        sum = op0 ^ op1 ^ cin;
        unique case (mode)
            CARRY_PASS: cout = cin;
            CARRY_ADD:  cout = (op0 & op1) | (op0 & cin) | (op1 & cin);
            CARRY_GEN:  cout = lut_o;
            default:    cout = 1'b0;
        endcase
    end
endmodule

// File: rtl/lb_out_ff.sv
// Output register with selectable data source and synchronous set/reset of
// programmable level; reset wins over set. Frozen while hold is high.
module lb_out_ff
    import lut_lb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hold,
    input  ff_src_e src,
    input  logic    d_comb,
    input  logic    d_direct,
    input  logic    d_carry,
    input  logic    sr_en,
    input  logic    sr_pol,
    input  logic    set_in,
    input  logic    rst_in,
    output logic    q
);
    logic set_act, rst_act;

    // Requests are active when enabled and at the programmed level.
    always_comb begin
        set_act = sr_en && (set_in == sr_pol);
        rst_act = sr_en && (rst_in == sr_pol);
    end

    // Register update: chip reset, freeze, user reset, user set, then data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (!hold) begin
            if (rst_act) begin
                q <= 1'b0;
            end else if (set_act) begin
                q <= 1'b1;
            end else begin
                unique case (src)
                    SRC_COMB:   q <= d_comb;
                    SRC_DIRECT: q <= d_direct;
                    SRC_CARRY:  q <= d_carry;
                    default:    q <= q;
                endcase
            end
        end
    end
endmodule

// File: rtl/lut_logic_block.sv
// Logic cell top: scan-loaded setup chain, K-input table or 2**K x 1 memory,
// carry stage and output flip-flop. Setup layout (LSB up): table, memory
// mode, carry mode, set/reset polarity, set/reset enable, ff source, spares.
module lut_logic_block
    import lut_lb_pkg::*;
#(
    parameter int K     = 4,
    parameter int SPARE = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_shift_en,
    input  logic         cfg_sin,
    output logic         cfg_sout,
    input  logic [K-1:0] a,
    input  logic         cin,
    input  logic         we,
    input  logic         wd,
    input  logic         d_in,
    input  logic         ff_set,
    input  logic         ff_rst,
    output logic         y,
    output logic         yq,
    output logic         cout
);
    localparam int TBL      = 1 << K;
    localparam int RAM_POS  = TBL;
    localparam int CM_POS   = TBL + 1;
    localparam int SRP_POS  = TBL + 3;
    localparam int SRE_POS  = TBL + 4;
    localparam int SRC_POS  = TBL + 5;
    localparam int CFG_BITS = TBL + MODE_BITS + SPARE;

    logic [CFG_BITS-1:0] cfg_q;
    logic                mem_wr, lut_o, sum;
    carry_mode_e         cmode;
    ff_src_e             fsrc;

    // Decode mode fields and gate memory writes by mode and shifting.
    always_comb begin
        cmode  = carry_mode_e'(cfg_q[CM_POS +: 2]);
        fsrc   = ff_src_e'(cfg_q[SRC_POS +: 2]);
        mem_wr = cfg_q[RAM_POS] && we && !cfg_shift_en;
    end

    lb_cfg_chain #(.N(CFG_BITS), .K(K)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .sin      (cfg_sin),
        .wr_en    (mem_wr),
        .wr_addr  (a),
        .wr_data  (wd),
        .cfg_q    (cfg_q),
        .sout     (cfg_sout)
    );

    lb_lut #(.K(K)) u_lut (
        .table_bits (cfg_q[TBL-1:0]),
        .sel        (a),
        .out        (lut_o)
    );

    lb_carry u_carry (
        .op0   (a[0]),
        .op1   (a[1]),
        .cin   (cin),
        .lut_o (lut_o),
        .mode  (cmode),
        .sum   (sum),
        .cout  (cout)
    );

    // Combinational output: adder sum in carry-add mode, table otherwise.
    assign y = (cmode == CARRY_ADD) ? sum : lut_o;

    lb_out_ff u_ff (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (cfg_shift_en),
        .src      (fsrc),
        .d_comb   (y),
        .d_direct (d_in),
        .d_carry  (cout),
        .sr_en    (cfg_q[SRE_POS]),
        .sr_pol   (cfg_q[SRP_POS]),
        .set_in   (ff_set),
        .rst_in   (ff_rst),
        .q        (yq)
    );
endmodule

// File: rtl/lut_lb_checker.sv
// Temporal checks for the logic cell, attached to every instance by bind.
// Observes ports and the setup register only.
module lut_lb_checker #(
    parameter int K     = 4,
    parameter int SPARE = 8,
    localparam int TBL      = 1 << K,
    localparam int RAM_POS  = TBL,
    localparam int CM_POS   = TBL + 1,
    localparam int SRP_POS  = TBL + 3,
    localparam int SRE_POS  = TBL + 4,
    localparam int CFG_BITS = TBL + 7 + SPARE
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_shift_en,
    input logic                cfg_sout,
    input logic [K-1:0]        a,
    input logic                cin,
    input logic                we,
    input logic                wd,
    input logic                ff_rst,
    input logic                y,
    input logic                yq,
    input logic                cout,
    input logic [CFG_BITS-1:0] cfg_q
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!yq && cfg_q == '0));

    // R2
    scan_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift_en |=> (cfg_sout == $past(cfg_q[1])));

    // R4
    ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[RAM_POS] && we && !cfg_shift_en) |=> (cfg_q[$past(a)] == $past(wd)));

    // R5
    rom_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q[RAM_POS] && !cfg_shift_en) |=> $stable(cfg_q[TBL-1:0]));

    // R6
    carry_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[CM_POS +: 2] == 2'b01) |->
        (cout == ((a[0] & a[1]) | (a[0] & cin) | (a[1] & cin)) && y == (a[0] ^ a[1] ^ cin)));

    // R8
    rst_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_shift_en && cfg_q[SRE_POS] && ff_rst == cfg_q[SRP_POS]) |=> !yq);

    // R9
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift_en |=> $stable(yq));
endmodule

bind lut_logic_block lut_lb_checker #(.K(K), .SPARE(SPARE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_shift_en (cfg_shift_en),
    .cfg_sout     (cfg_sout),
    .a            (a),
    .cin          (cin),
    .we           (we),
    .wd           (wd),
    .ff_rst       (ff_rst),
    .y            (y),
    .yq           (yq),
    .cout         (cout),
    .cfg_q        (cfg_q)
);

// File: tb/lut_logic_block_test.sv
module lut_logic_block_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCFG = 31;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n, cfg_shift_en, cfg_sin, cfg_sout, cin, we, wd, d_in, ff_set, ff_rst;
    logic y, yq, cout;
    logic [3:0] a;

    lut_logic_block uut (
        .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_sin(cfg_sin),
        .cfg_sout(cfg_sout), .a(a), .cin(cin), .we(we), .wd(wd), .d_in(d_in),
        .ff_set(ff_set), .ff_rst(ff_rst), .y(y), .yq(yq), .cout(cout)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Setup word: {spare, src, sr_en, sr_pol, carry mode, mem mode, table}
    function automatic logic [30:0] mk(input logic [15:0] t, input logic ram,
                                       input logic [1:0] cm, input logic pol,
                                       input logic en, input logic [1:0] src,
                                       input logic [7:0] sp);
        return {sp, src, en, pol, cm, ram, t};
    endfunction

    // Shift a new word in LSB first while capturing the old one.
    task automatic shift_word(input logic [30:0] v, output logic [30:0] old);
        for (int i = 0; i < NCFG; i++) begin
            cfg_sin = v[i];
            cfg_shift_en = 1'b1;
            #1 old[i] = cfg_sout;
            tick();
        end
        cfg_shift_en = 1'b0;
    endtask

    task automatic load(input logic [30:0] v);
        logic [30:0] dummy;
        shift_word(v, dummy);
    endtask

    initial begin
        logic [30:0] old, w;
        logic [15:0] tabs [4];
        logic [15:0] pat, t;
        tabs[0] = 16'hCAFE; tabs[1] = 16'h8000; tabs[2] = 16'h6996; tabs[3] = 16'hFFFE;

        rst_n = 1'b0; cfg_shift_en = 1'b0; cfg_sin = 1'b0; a = 4'h0; cin = 1'b1;
        we = 1'b0; wd = 1'b0; d_in = 1'b1; ff_set = 1'b0; ff_rst = 1'b0;
        tick(); tick();
        // R1 reset state
        check("R1 yq after reset", yq, 1'b0);
        check("R1 cout follows cin after reset", cout, 1'b1);
        rst_n = 1'b1;

        // R1 / R2: reset contents read out as zero; readback in LSB-first order
        w = mk(16'hA5C3, 1'b0, 2'b10, 1'b1, 1'b0, 2'b01, 8'h9D);
        shift_word(w, old);
        check("R1 setup bits cleared", old, 31'h0);
        shift_word(31'h0, old);
        check("R2 scan readback", old, w);

        // R3: table sweep for several functions
        foreach (tabs[k]) begin
            load(mk(tabs[k], 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 8'h00));
            for (int i = 0; i < 16; i++) begin
                a = 4'(i);
                #1 check("R3 table output", y, tabs[k][i]);
            end
        end

        // R6: carry-add mode, all operand combinations
        load(mk(16'h0000, 1'b0, 2'b01, 1'b0, 1'b0, 2'b00, 8'h00));
        for (int i = 0; i < 8; i++) begin
            a = {2'b10, i[1], i[0]};
            cin = i[2];
            #1;
            check("R6 add sum", y, i[0] ^ i[1] ^ i[2]);
            check("R6 add carry", cout, (i[0] & i[1]) | (i[0] & i[2]) | (i[1] & i[2]));
        end

        // R6: pass, generate and zero carry modes
        t = 16'hF0F0;
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            load(mk(t, 1'b0, 2'(m), 1'b0, 1'b0, 2'b00, 8'h00));
            for (int i = 0; i < 32; i++) begin
                a = 4'(i >> 1);
                cin = i[0];
                #1;
                check("R6 table kept on y", y, t[i >> 1]);
                check("R6 carry mode", cout,
                      (m == 0) ? i[0] : (m == 2) ? t[i >> 1] : 1'b0);
            end
        end
        cin = 1'b0;

        // R4: memory mode writes, immediate read, scan readback
        pat = 16'h3C5A;
        load(mk(16'h0000, 1'b1, 2'b00, 1'b0, 1'b0, 2'b11, 8'h00));
        for (int i = 0; i < 16; i++) begin
            a = 4'(i); wd = pat[i]; we = 1'b1;
            tick();
            check("R4 read right after write", y, pat[i]);
        end
        we = 1'b0;
        for (int i = 0; i < 16; i++) begin
            a = 4'(i); wd = ~pat[i];
            #1 check("R4 memory read", y, pat[i]);
        end
        shift_word(31'h0, old);
        check("R4 written bits in scan", old[16:0], {1'b1, pat});

        // R5: writes ignored when memory mode is off
        t = 16'h1234;
        load(mk(t, 1'b0, 2'b00, 1'b0, 1'b0, 2'b11, 8'h00));
        for (int i = 0; i < 16; i++) begin
            a = 4'(i); wd = ~t[i]; we = 1'b1;
            tick();
        end
        we = 1'b0;
        for (int i = 0; i < 16; i++) begin
            a = 4'(i);
            #1 check("R5 table unchanged", y, t[i]);
        end
        shift_word(31'h0, old);
        check("R5 scan unchanged", old[15:0], t);

        // R7: flip-flop sources (table AAAA gives y = a[0]; pass carry gives cout = cin)
        load(mk(16'hAAAA, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 8'h00));
        d_in = 1'b0; cin = 1'b0; a = 4'h1; tick();
        check("R7 source y high", yq, 1'b1);
        a = 4'h0; tick();
        check("R7 source y low", yq, 1'b0);
        load(mk(16'hAAAA, 1'b0, 2'b00, 1'b0, 1'b0, 2'b01, 8'h00));
        d_in = 1'b1; tick();
        check("R7 source d_in high", yq, 1'b1);
        d_in = 1'b0; tick();
        check("R7 source d_in low", yq, 1'b0);
        load(mk(16'hAAAA, 1'b0, 2'b00, 1'b0, 1'b0, 2'b10, 8'h00));
        cin = 1'b1; tick();
        check("R7 source cout high", yq, 1'b1);
        cin = 1'b0; tick();
        check("R7 source cout low", yq, 1'b0);
        load(mk(16'hAAAA, 1'b0, 2'b00, 1'b0, 1'b0, 2'b01, 8'h00));
        d_in = 1'b1; tick();
        check("R7 preset via d_in", yq, 1'b1);
        // R9: yq frozen while shifting even though d_in would clear it
        d_in = 1'b0;
        load(mk(16'hAAAA, 1'b0, 2'b00, 1'b0, 1'b0, 2'b11, 8'h00));
        check("R9 yq held during shift", yq, 1'b1);
        a = 4'h0; tick(); a = 4'h1; tick();
        check("R7 hold source", yq, 1'b1);

        // R8: set/reset active high, reset wins
        load(mk(16'h0000, 1'b0, 2'b00, 1'b1, 1'b1, 2'b01, 8'h00));
        d_in = 1'b0; ff_set = 1'b1; ff_rst = 1'b0; tick();
        check("R8 set active high", yq, 1'b1);
        ff_rst = 1'b1; tick();
        check("R8 reset over set", yq, 1'b0);
        ff_rst = 1'b0; tick();
        check("R8 set again", yq, 1'b1);
        ff_set = 1'b0; ff_rst = 1'b1; tick();
        check("R8 reset alone", yq, 1'b0);
        // R8: active low
        load(mk(16'h0000, 1'b0, 2'b00, 1'b0, 1'b1, 2'b01, 8'h00));
        ff_set = 1'b1; ff_rst = 1'b1; d_in = 1'b1; tick();
        check("R8 low level inactive when high", yq, 1'b1);
        ff_rst = 1'b0; tick();
        check("R8 reset active low", yq, 1'b0);
        ff_rst = 1'b1; ff_set = 1'b0; d_in = 1'b0; tick();
        check("R8 set active low", yq, 1'b1);
        // R8: disabled
        load(mk(16'h0000, 1'b0, 2'b00, 1'b1, 1'b0, 2'b01, 8'h00));
        ff_set = 1'b0; ff_rst = 1'b1; d_in = 1'b1; tick();
        check("R8 disabled reset ignored", yq, 1'b1);
        ff_rst = 1'b0; ff_set = 1'b1; d_in = 1'b0; tick();
        check("R8 disabled set ignored", yq, 1'b0);
        ff_set = 1'b0;

        // R1: reset in mid-operation
        d_in = 1'b1; tick();
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        check("R1 yq cleared mid-run", yq, 1'b0);
        shift_word(31'h0, old);
        check("R1 setup cleared mid-run", old, 31'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule